// File: doc/BRIEF.md
# Multi-Kernel Workgroup Dispatch Scheduler

This block sits between a kernel launch path and a pool of compute resources. Each launch names a kernel slot and gives a three-dimensional global size and a workgroup size. The block derives the workgroup grid from those two sizes, queues the kernel, and then offers that kernel's workgroups one per cycle in a fixed order. A downstream placement stage answers each offer in the same cycle with an accept bit that says whether the workgroup fits.

When an offer is refused, the scheduler does not stall. It moves the kernel to the back of its queue, counts the refusal and tries the next kernel, because a kernel with smaller workgroups may still fit. A scheduling pass ends as soon as every kernel still queued has been refused once in that pass. A kernel launch or a workgroup-completion report starts the next pass. A refused kernel keeps its position in its own grid, so the same workgroup is offered again in a later pass.

Top module: `wg_dispatch_sched`

## Requirements
- R1: The per-dimension workgroup count is ceil(global / local) and the kernel issues exactly the product of the three counts. Size fields are packed with x in bits [SIZE_W-1:0], y in the next SIZE_W bits and z in the top SIZE_W bits.
- R2: A kernel's first workgroup has x = y = z = 0 and flat ID 0. Each later workgroup advances x first, wrapping into y and then z. The flat ID rises by one per issued workgroup.
- R3: While the head kernel still has workgroups and each offer is accepted, its workgroups are offered on consecutive cycles.
- R4: A refused offer moves that kernel to the back of the queue without advancing its IDs. The refused workgroup is the next one offered for that kernel.
- R5: After its last workgroup is accepted, a kernel leaves the queue and `pending_kernels` drops by one.
- R6: A pass ends, and `busy` falls, once the queue length is no greater than the number of refusals in that pass. When every offer is refused, each queued kernel is offered exactly once, in queue order.
- R7: An accepted launch, or a pulse on `wg_done`, starts a pass. Its first offer is visible in the cycle after that event. An event that arrives during a pass causes one more pass after the current one.
- R8: A workgroup size of zero in any dimension is treated as one.
- R9: A launch that arrives while the queue holds NUM_KERNELS entries is ignored. It changes neither the queue nor the stored grid, and it does not start a pass.
- R10: A kernel whose workgroup total is zero leaves the queue without making any offer.
- R11: After reset, `wg_valid` and `busy` are low and `pending_kernels` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_valid | input | 1 | Launch strobe for one cycle |
| launch_kid | input | KID_W | Kernel slot being launched |
| launch_global | input | 3*SIZE_W | Global size {z, y, x} |
| launch_local | input | 3*SIZE_W | Workgroup size {z, y, x} |
| wg_done | input | 1 | Workgroup-completion event; requests a pass |
| wg_accept | input | 1 | Same-cycle answer to the current offer |
| wg_valid | output | 1 | A workgroup is offered this cycle |
| wg_kid | output | KID_W | Kernel slot of the offer |
| wg_x | output | SIZE_W | X workgroup ID |
| wg_y | output | SIZE_W | Y workgroup ID |
| wg_z | output | SIZE_W | Z workgroup ID |
| wg_gid | output | 3*SIZE_W | Flat workgroup ID within the kernel |
| busy | output | 1 | A pass is in progress |
| pending_kernels | output | CNT_W | Number of kernels queued |

## Verification
The hardest state to reach is a pass that ends while a kernel that was refused earlier still has work. Reaching it needs a refusal followed by another kernel draining completely, so that the queue length falls to the refusal count. The stimulus first loads two kernels behind passes in which every offer is refused, which leaves the queue order unchanged. It then starts a pass with a completion pulse while an accept policy refuses only the first kernel's first offer. That pass must stop with one kernel pending. A second completion pulse must then resume the refused kernel at ID zero.

// File: rtl/wg_sched_pkg.sv
package wg_sched_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_ISSUE  = 2'd1,
    ACT_REFUSE = 2'd2,
    ACT_DROP   = 2'd3
  } sched_act_e;
endpackage

// File: rtl/wg_grid_calc.sv
module wg_grid_calc #(
  parameter int SIZE_W = 8,
  localparam int GID_W = 3 * SIZE_W
) (
  input  logic [2:0][SIZE_W-1:0] glob,
  input  logic [2:0][SIZE_W-1:0] lsz,
  output logic [2:0][SIZE_W-1:0] cnt,
  output logic [GID_W-1:0]       total
);
  for (genvar d = 0; d < 3; d++) begin : g_dim
    logic [SIZE_W:0] l_eff;
    logic [SIZE_W:0] num;
    // zero-sized workgroup dimension behaves as size one (R8)
    assign l_eff  = (lsz[d] == '0) ? (SIZE_W+1)'(1) : {1'b0, lsz[d]};
    assign num    = {1'b0, glob[d]} + l_eff - (SIZE_W+1)'(1);
    assign cnt[d] = SIZE_W'(num / l_eff);
  end

  assign total = GID_W'(cnt[0]) * GID_W'(cnt[1]) * GID_W'(cnt[2]);
endmodule

// File: rtl/wg_id_stepper.sv
module wg_id_stepper #(
  parameter int SIZE_W = 8,
  localparam int GID_W = 3 * SIZE_W
) (
  input  logic [2:0][SIZE_W-1:0] id,
  input  logic [2:0][SIZE_W-1:0] n,
  input  logic [GID_W-1:0]       gid,
  output logic [2:0][SIZE_W-1:0] nid,
  output logic [GID_W-1:0]       ngid,
  output logic                   last
);
  logic [3:0] carry;
  logic [2:0] at_end;

  assign carry[0] = 1'b1;
  for (genvar d = 0; d < 3; d++) begin : g_dim
    assign at_end[d]  = (id[d] == n[d] - SIZE_W'(1));
    assign carry[d+1] = carry[d] & at_end[d];
    assign nid[d]     = !carry[d] ? id[d] :
                        (at_end[d] ? '0 : id[d] + SIZE_W'(1));
  end

  assign last = carry[3];
  assign ngid = gid + GID_W'(1);
endmodule

// File: rtl/wg_kernel_queue.sv
module wg_kernel_queue #(
  parameter int DEPTH = 4,
  parameter int ID_W  = 2,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop,
  input  logic             rot,
  input  logic             push,
  input  logic [ID_W-1:0]  push_id,
  output logic [ID_W-1:0]  head,
  output logic [CNT_W-1:0] count
);
  logic [ID_W-1:0]  slot_q [DEPTH];
  logic [ID_W-1:0]  slot_d [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
    cnt_d = cnt_q;
    if (pop || rot) begin
      for (int i = 0; i < DEPTH - 1; i++) slot_d[i] = slot_q[i+1];
      if (pop) cnt_d = cnt_q - CNT_W'(1);
      else     slot_d[IDX_W'(cnt_q - CNT_W'(1))] = slot_q[0];
    end
    if (push) begin
      slot_d[IDX_W'(cnt_d)] = push_id;
      cnt_d = cnt_d + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
  end

  assign head  = slot_q[0];
  assign count = cnt_q;

  AST_Q_NEVER_OVER: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH)); // R9
  AST_Q_ROT_KEEPS_LEN: assert property (@(posedge clk) disable iff (rst)
    (rot && !push) |=> (cnt_q == $past(cnt_q))); // R4
endmodule

// File: rtl/wg_dispatch_sched.sv
module wg_dispatch_sched
  import wg_sched_pkg::*;
#(
  parameter int NUM_KERNELS = 4,
  parameter int SIZE_W = 8,
  localparam int KID_W = $clog2(NUM_KERNELS),
  localparam int GID_W = 3 * SIZE_W,
  localparam int CNT_W = $clog2(NUM_KERNELS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch_valid,
  input  logic [KID_W-1:0]   launch_kid,
  input  logic [GID_W-1:0]   launch_global,
  input  logic [GID_W-1:0]   launch_local,
  input  logic               wg_done,
  input  logic               wg_accept,
  output logic               wg_valid,
  output logic [KID_W-1:0]   wg_kid,
  output logic [SIZE_W-1:0]  wg_x,
  output logic [SIZE_W-1:0]  wg_y,
  output logic [SIZE_W-1:0]  wg_z,
  output logic [GID_W-1:0]   wg_gid,
  output logic               busy,
  output logic [CNT_W-1:0]   pending_kernels
);
  // per-kernel grid state
  logic [2:0][SIZE_W-1:0] nwg_q   [NUM_KERNELS];
  logic [2:0][SIZE_W-1:0] id_q    [NUM_KERNELS];
  logic [GID_W-1:0]       gid_q   [NUM_KERNELS];
  logic [GID_W-1:0]       total_q [NUM_KERNELS];
  logic [NUM_KERNELS-1:0] rem_q;

  // pass control
  logic             active_q, pend_q;
  logic [CNT_W-1:0] fail_q;

  logic [2:0][SIZE_W-1:0] new_n, step_id;
  logic [GID_W-1:0]       new_total, step_gid;
  logic                   step_last;
  logic [KID_W-1:0]       head;
  logic [CNT_W-1:0]       q_cnt;
  logic                   pass_end, launch_ok, ev, start;
  sched_act_e             act;

  wg_grid_calc #(.SIZE_W(SIZE_W)) u_grid (
    .glob (launch_global),
    .lsz  (launch_local),
    .cnt  (new_n),
    .total(new_total)
  );

  wg_id_stepper #(.SIZE_W(SIZE_W)) u_step (
    .id  (id_q[head]),
    .n   (nwg_q[head]),
    .gid (gid_q[head]),
    .nid (step_id),
    .ngid(step_gid),
    .last(step_last)
  );

  wg_kernel_queue #(.DEPTH(NUM_KERNELS), .ID_W(KID_W)) u_queue (
    .clk    (clk),
    .rst    (rst),
    .pop    ((act == ACT_ISSUE && step_last) || act == ACT_DROP),
    .rot    (act == ACT_REFUSE),
    .push   (launch_ok),
    .push_id(launch_kid),
    .head   (head),
    .count  (q_cnt)
  );

  assign pass_end  = active_q && (q_cnt <= fail_q);
  assign launch_ok = launch_valid && (q_cnt != CNT_W'(NUM_KERNELS));
  assign ev        = launch_ok || wg_done;
  assign start     = (!active_q || pass_end) && (ev || pend_q);

  always_comb begin
    act = ACT_NONE;
    if (active_q && !pass_end) begin
      if (!rem_q[head])   act = ACT_DROP;
      else if (wg_accept) act = ACT_ISSUE;
      else                act = ACT_REFUSE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      fail_q   <= '0;
      rem_q    <= '0;
    end else begin
      if (start) begin
        active_q <= 1'b1;
        pend_q   <= 1'b0;
        fail_q   <= '0;
      end else if (pass_end) begin
        active_q <= 1'b0;
      end else begin
        if (act == ACT_REFUSE) fail_q <= fail_q + CNT_W'(1);
        if (ev && active_q)    pend_q <= 1'b1;
      end
      if (act == ACT_ISSUE && step_last) rem_q[head] <= 1'b0;
      if (launch_ok) rem_q[launch_kid] <= (new_total != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (act == ACT_ISSUE) begin
      id_q[head]  <= step_id;
      gid_q[head] <= step_gid;
    end
    if (launch_ok) begin
      nwg_q[launch_kid]   <= new_n;
      id_q[launch_kid]    <= '0;
      gid_q[launch_kid]   <= '0;
      total_q[launch_kid] <= new_total;
    end
  end

  assign wg_valid        = active_q && !pass_end && rem_q[head];
  assign wg_kid          = head;
  assign wg_x            = id_q[head][0];
  assign wg_y            = id_q[head][1];
  assign wg_z            = id_q[head][2];
  assign wg_gid          = gid_q[head];
  assign busy            = active_q;
  assign pending_kernels = q_cnt;

  AST_LAST_GID_IS_TOTAL: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_ISSUE && step_last) |-> (wg_gid == total_q[head] - GID_W'(1))); // R1
  AST_X_STEPS_FIRST: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_ISSUE && !step_last && !launch_valid && (wg_x != nwg_q[head][0] - SIZE_W'(1)))
    |=> (wg_valid && wg_x == $past(wg_x) + SIZE_W'(1) && wg_y == $past(wg_y) && wg_z == $past(wg_z))); // R2
  AST_FAIL_WITHIN_LEN: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (fail_q <= q_cnt)); // R6
  AST_REFUSE_HOLDS_ID: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_REFUSE && !launch_valid) |=> (gid_q[$past(head)] == $past(wg_gid))); // R4
endmodule

// File: tb/wg_dispatch_sched_bench.sv
module wg_dispatch_sched_bench;
  localparam int NK = 4;
  localparam int SW = 8;
  localparam int KW = $clog2(NK);
  localparam int GW = 3 * SW;
  localparam int CW = $clog2(NK + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, launch_valid, wg_done, wg_accept;
  logic [KW-1:0] launch_kid;
  logic [GW-1:0] launch_global, launch_local;
  logic          wg_valid, busy;
  logic [KW-1:0] wg_kid;
  logic [SW-1:0] wg_x, wg_y, wg_z;
  logic [GW-1:0] wg_gid;
  logic [CW-1:0] pending_kernels;

  wg_dispatch_sched #(.NUM_KERNELS(NK), .SIZE_W(SW)) u_wg_dispatch_sched (
    .clk(clk), .rst(rst), .launch_valid(launch_valid), .launch_kid(launch_kid),
    .launch_global(launch_global), .launch_local(launch_local),
    .wg_done(wg_done), .wg_accept(wg_accept), .wg_valid(wg_valid),
    .wg_kid(wg_kid), .wg_x(wg_x), .wg_y(wg_y), .wg_z(wg_z), .wg_gid(wg_gid),
    .busy(busy), .pending_kernels(pending_kernels)
  );

  int n_chk = 0, n_fail = 0, cyc_total = 0;
  int n_rec;
  int rec_kid [64], rec_x [64], rec_y [64], rec_z [64], rec_gid [64], rec_acc [64], rec_cyc [64];

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc_total);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic launch(int kid, int gx, int gy, int gz, int lx, int ly, int lz);
    @(negedge clk);
    launch_valid  = 1'b1;
    launch_kid    = KW'(kid);
    launch_global = {SW'(gz), SW'(gy), SW'(gx)};
    launch_local  = {SW'(lz), SW'(ly), SW'(lx)};
    @(negedge clk);
    launch_valid  = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    wg_done = 1'b1;
    @(negedge clk);
    wg_done = 1'b0;
  endtask

  // policy 0: refuse all, 1: accept all, 2: refuse first offer of pol_kid only
  task automatic run_pass(int policy, int pol_kid);
    int cyc = 0;
    bit used = 1'b0;
    n_rec = 0;
    while (busy && cyc < 400) begin
      if (wg_valid) begin
        bit acc;
        acc = (policy == 1);
        if (policy == 2) begin
          acc = 1'b1;
          if (int'(wg_kid) == pol_kid && !used) begin acc = 1'b0; used = 1'b1; end
        end
        if (n_rec < 64) begin
          rec_kid[n_rec] = int'(wg_kid); rec_x[n_rec] = int'(wg_x);
          rec_y[n_rec] = int'(wg_y);     rec_z[n_rec] = int'(wg_z);
          rec_gid[n_rec] = int'(wg_gid); rec_acc[n_rec] = int'(acc);
          rec_cyc[n_rec] = cyc;
          n_rec++;
        end
        wg_accept = acc;
      end else begin
        wg_accept = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    wg_accept = 1'b0;
  endtask

  task automatic load(int kid, int gx, int gy, int gz);
    launch(kid, gx, gy, gz, 1, 1, 1);
    run_pass(0, 0);
  endtask

  task automatic t_reset();
    chk("R11 wg_valid", int'(wg_valid), 0);
    chk("R11 busy", int'(busy), 0);
    chk("R11 pending", int'(pending_kernels), 0);
  endtask

  task automatic t_grid();
    launch(1, 5, 3, 2, 2, 2, 1);
    run_pass(1, 0);
    chk("R1 total issued", n_rec, 12);
    for (int i = 0; i < 12; i++) begin
      chk("R2 x", rec_x[i], i % 3);
      chk("R2 y", rec_y[i], (i / 3) % 2);
      chk("R2 z", rec_z[i], i / 6);
      chk("R2 gid", rec_gid[i], i);
      chk("R3 back-to-back", rec_cyc[i], i);
    end
    chk("R5 kernel removed", int'(pending_kernels), 0);
    chk("R6 busy low", int'(busy), 0);
  endtask

  task automatic t_zero_local();
    launch(2, 3, 2, 1, 0, 1, 0);
    run_pass(1, 0);
    chk("R8 count", n_rec, 6);
    chk("R8 last x", rec_x[5], 2);
    chk("R8 last y", rec_y[5], 1);
    chk("R8 last gid", rec_gid[5], 5);
  endtask

  task automatic t_zero_global();
    launch(3, 0, 4, 4, 1, 1, 1);
    run_pass(1, 0);
    chk("R10 no offers", n_rec, 0);
    chk("R10 removed", int'(pending_kernels), 0);
  endtask

  task automatic t_all_refuse();
    load(0, 1, 1, 1);
    load(1, 1, 1, 1);
    load(2, 1, 1, 1);
    pulse_done();
    run_pass(0, 0);
    chk("R6 one offer each", n_rec, 3);
    for (int i = 0; i < 3; i++) chk("R6 queue order", rec_kid[i], i);
    chk("R6 pending kept", int'(pending_kernels), 3);
    pulse_done();
    run_pass(1, 0);
    chk("R5 drained", n_rec, 3);
    chk("R5 pending zero", int'(pending_kernels), 0);
  endtask

  task automatic t_rotate();
    load(1, 2, 1, 1);
    load(2, 1, 2, 1);
    pulse_done();
    run_pass(2, 1);
    chk("R7 first offer next cycle", rec_cyc[0], 0);
    chk("R6 pass stops early", n_rec, 3);
    chk("R4 refused kid", rec_kid[0], 1);
    chk("R4 refused", rec_acc[0], 0);
    chk("R4 next kernel", rec_kid[1], 2);
    chk("R4 next kernel y", rec_y[2], 1);
    chk("R6 one left", int'(pending_kernels), 1);
    pulse_done();
    run_pass(1, 0);
    chk("R4 resumed count", n_rec, 2);
    chk("R4 resumed kid", rec_kid[0], 1);
    chk("R4 resumed gid", rec_gid[0], 0);
    chk("R4 second x", rec_x[1], 1);
    chk("R5 all gone", int'(pending_kernels), 0);
  endtask

  task automatic t_full();
    for (int k = 0; k < NK; k++) load(k, 1, 1, 1);
    chk("R9 queue full", int'(pending_kernels), NK);
    launch(0, 4, 1, 1, 1, 1, 1);
    chk("R9 no pass", int'(busy), 0);
    chk("R9 length kept", int'(pending_kernels), NK);
    pulse_done();
    run_pass(1, 0);
    chk("R9 offers", n_rec, NK);
    chk("R9 kernel 0 grid kept", rec_gid[0], 0);
    chk("R9 kernel 0 first", rec_kid[0], 0);
    chk("R9 drained", int'(pending_kernels), 0);
  endtask

  initial begin
    rst = 1'b1; launch_valid = 1'b0; wg_done = 1'b0; wg_accept = 1'b0;
    launch_kid = '0; launch_global = '0; launch_local = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_grid();
    t_zero_local();
    t_zero_global();
    t_all_refuse();
    t_rotate();
    t_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule